// File: doc/BRIEF.md
# Width-Adaptive Operand Read Sequencer

This block is a bus-master read engine. A core hands it one read of a byte, a word or a long word at an aligned address. The engine fetches the operand over a 32-bit data bus from slaves that may be 8, 16 or 32 bits wide. It does not know the slave's width in advance. Every bus cycle opens as though the slave were full width and asks for all of the bytes still owed. The slave ends the cycle with a 2-bit active-low acknowledge, and that code also tells the engine how wide the port is. The engine picks the valid bytes off the fixed upper lanes that such a port uses, and writes them into their places in the operand. If bytes are still missing, it opens another cycle at the next address. When the operand is whole, it returns the value right-justified.

The request side is a valid/ready stream. `req_ready` is high only while the engine is idle, and that includes the cycle that carries the completion pulse. A request counts as accepted on a clock edge where both `req_valid` and `req_ready` are high. The core must hold the request unchanged until that edge. An offer made while `req_ready` is low is not taken. The response side cannot apply back-pressure: `rsp_valid` is high for exactly one clock, and `rsp_data` is meaningful only in that clock.

Top module: `dbs_read_seq`

## Requirements
- R1: After reset, `bus_strobe` is 0, `req_ready` is 1, `rsp_valid` is 0 and `rsp_data` is 0.
- R2: A request is taken only on an edge where `req_ready` is high. `req_ready` is low while a transfer is under way, and an offer made then starts no bus cycle and leaves the operand in flight unchanged.
- R3: The first bus cycle of a transfer drives `bus_addr` equal to the request address. `bus_siz` carries the full size in the code 01 = one byte, 10 = two bytes, 11 = three bytes, 00 = four bytes. `req_size` uses the same code.
- R4: `bus_ack_n` = 11 (bit 1 and bit 0 both high) is a wait state. The strobe stays high, and `bus_addr` and `bus_siz` stay unchanged, until a terminating code arrives.
- R5: Code 00 ends the cycle on a 32-bit port. The byte at address offset o within the aligned 32-bit word is taken from lane o, where lane 0 is bits 31:24 and lane 3 is bits 7:0.
- R6: Code 10 (bit 1 high, bit 0 low) ends the cycle on an 8-bit port, and the byte comes from bits 31:24 only. Code 01 ends it on a 16-bit port, using bits 31:16 only, with the byte at an even address on 31:24 and the one at an odd address on 23:16. Bytes on all other lanes are ignored.
- R7: A long-word read answered as a 16-bit port takes exactly two bus cycles: the first at A with size 00, the second at A+2 with size 10.
- R8: A long-word read answered as an 8-bit port takes four bus cycles, at A, A+1, A+2 and A+3, with sizes 00, 11, 10 and 01. After every partial completion, the address rises by the bytes just taken and the size drops by the same number.
- R9: A 32-bit acknowledge to a byte or word request completes the transfer in that one bus cycle.
- R10: `bus_strobe` goes low for at least one clock after every terminated bus cycle before the next one begins.
- R11: When the last byte is taken, `rsp_valid` pulses for one clock. `rsp_data` then holds the operand right-justified, with the byte at the lowest address most significant and the bytes above the operand zero.
- R12: A synchronous reset during a transfer returns the engine to idle with the strobe low and `rsp_data` cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a read |
| req_ready | output | 1 | Engine idle and able to take a read |
| req_size | input | 2 | Operand size code (01 byte, 10 word, 00 long) |
| req_addr | input | ADDR_W | Aligned operand address |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_siz | output | 2 | Bytes still owed, same code as req_size |
| bus_strobe | output | 1 | Bus cycle in progress, active high |
| bus_data | input | 32 | Read data from the slave |
| bus_ack_n | input | 2 | Active-low termination and port width code |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | 32 | Assembled operand, right-justified |

## Verification
Two events can fall in one clock: the completion pulse of one operand and the acceptance of the next request, because `req_ready` is already high while `rsp_valid` is. The bench provokes this by raising a new request in the very clock where it first sees `rsp_valid`. It then judges three things: the finished operand is still intact in that clock, the new transfer's first bus cycle carries the new address and full size, and the second operand assembles cleanly from a cleared register. A second overlap, a partial completion with the engine's address advance, is judged by the exact address and size sequence that the bench logs for each bus cycle.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int CNT_W  = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    PORT_WAIT = 2'd0,
    PORT_8    = 2'd1,
    PORT_16   = 2'd2,
    PORT_32   = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;

  // size code: 00 means a full word of LANES bytes, otherwise the byte count
  function automatic logic [CNT_W-1:0] code_to_bytes(input logic [1:0] code);
    if (code == 2'b00) return CNT_W'(LANES);
    return CNT_W'(code);
  endfunction
endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode
  import dbs_pkg::*;
(
  input  logic [1:0]       ack_n,
  output port_e            port,
  output logic             term,
  output logic [CNT_W-1:0] port_bytes
);
  always_comb begin
    unique case (ack_n)
      2'b11: begin port = PORT_WAIT; port_bytes = CNT_W'(0); end
      2'b10: begin port = PORT_8;    port_bytes = CNT_W'(1); end
      2'b01: begin port = PORT_16;   port_bytes = CNT_W'(2); end
      default: begin port = PORT_32; port_bytes = CNT_W'(LANES); end
    endcase
    term = (port != PORT_WAIT);
  end
endmodule

// File: rtl/dbs_cycle_ctrl.sv
module dbs_cycle_ctrl
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              term,
  input  logic [CNT_W-1:0]  port_bytes,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_strobe,
  output logic              accept,
  output logic              capture,
  output logic [CNT_W-1:0]  take,
  output logic [CNT_W-1:0]  done_bytes,
  output logic [CNT_W-1:0]  op_bytes,
  output logic              rsp_valid
);
  seq_st_e           st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  total_q;
  logic [CNT_W-1:0]  done_q;
  logic              last;

  assign req_ready  = (st == ST_IDLE);
  assign bus_strobe = (st == ST_BUS);
  assign bus_addr   = addr_q;
  assign bus_siz    = rem_q[1:0];
  assign accept     = req_ready && req_valid;
  assign capture    = bus_strobe && term;
  assign take       = (port_bytes < rem_q) ? port_bytes : rem_q;
  assign last       = (take == rem_q);
  assign done_bytes = done_q;
  assign op_bytes   = total_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      total_q   <= '0;
      done_q    <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            rem_q   <= code_to_bytes(req_size);
            total_q <= code_to_bytes(req_size);
            done_q  <= '0;
            st      <= ST_BUS;
          end
        end
        ST_BUS: begin
          if (term) begin
            addr_q <= addr_q + ADDR_W'(take);
            rem_q  <= rem_q - take;
            done_q <= done_q + take;
            if (last) begin
              st        <= ST_IDLE;
              rsp_valid <= 1'b1;
            end else begin
              st <= ST_GAP;
            end
          end
        end
        default: st <= ST_BUS;
      endcase
    end
  end

  assert_first_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (bus_strobe && bus_addr == $past(req_addr) && bus_siz == $past(req_size)));

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && !term) |=> (bus_strobe && $stable(bus_addr) && $stable(bus_siz)));

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
    bus_strobe |-> !req_ready);

  assert_full_port_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && term && port_bytes == CNT_W'(LANES)) |=> rsp_valid);

  assert_strobe_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && term) |=> !bus_strobe);

  assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && term && !last) |=> ##1
      (bus_strobe && bus_addr == $past(bus_addr, 2) + ADDR_W'($past(take, 2))
       && bus_siz == 2'($past(rem_q, 2) - $past(take, 2))));
endmodule

// File: rtl/dbs_operand_asm.sv
module dbs_operand_asm
  import dbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              capture,
  input  port_e             port,
  input  logic [1:0]        addr_low,
  input  logic [CNT_W-1:0]  op_bytes,
  input  logic [CNT_W-1:0]  done_bytes,
  input  logic [CNT_W-1:0]  take,
  input  logic [DATA_W-1:0] bus_data,
  output logic [DATA_W-1:0] operand
);
  logic [LANES-1:0] slot_we;
  logic [7:0]       slot_d [LANES];

  // slot r is result byte r counted from the least significant end
  for (genvar r = 0; r < LANES; r++) begin : g_slot
    always_comb begin
      int k;
      int m;
      int lane;
      k = int'(op_bytes) - 1 - r;
      slot_we[r] = capture && (k >= int'(done_bytes)) && (k < int'(done_bytes) + int'(take));
      m = slot_we[r] ? (k - int'(done_bytes)) : 0;
      unique case (port)
        PORT_32: lane = (int'(addr_low) + m) % LANES;
        PORT_16: lane = (int'(addr_low) + m) % 2;
        default: lane = 0;
      endcase
      slot_d[r] = bus_data[DATA_W - 8 - 8*lane +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      operand <= '0;
    end else begin
      for (int r = 0; r < LANES; r++) begin
        if (slot_we[r]) operand[8*r +: 8] <= slot_d[r];
      end
    end
  end

  assert_no_clear_during_capture_R2: assert property (@(posedge clk) disable iff (rst)
    !(clear && capture));

  assert_fill_from_zero_R11: assert property (@(posedge clk) disable iff (rst)
    clear |=> (operand == '0));
endmodule

// File: rtl/dbs_read_seq.sv
module dbs_read_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_strobe,
  input  logic [31:0]       bus_data,
  input  logic [1:0]        bus_ack_n,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data
);
  port_e            port;
  logic             term;
  logic [CNT_W-1:0] port_bytes;
  logic             accept;
  logic             capture;
  logic [CNT_W-1:0] take;
  logic [CNT_W-1:0] done_bytes;
  logic [CNT_W-1:0] op_bytes;

  dbs_ack_decode u_dec (
    .ack_n      (bus_ack_n),
    .port       (port),
    .term       (term),
    .port_bytes (port_bytes)
  );

  dbs_cycle_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_ready  (req_ready),
    .term       (term),
    .port_bytes (port_bytes),
    .bus_addr   (bus_addr),
    .bus_siz    (bus_siz),
    .bus_strobe (bus_strobe),
    .accept     (accept),
    .capture    (capture),
    .take       (take),
    .done_bytes (done_bytes),
    .op_bytes   (op_bytes),
    .rsp_valid  (rsp_valid)
  );

  dbs_operand_asm u_asm (
    .clk        (clk),
    .rst        (rst),
    .clear      (accept),
    .capture    (capture),
    .port       (port),
    .addr_low   (bus_addr[1:0]),
    .op_bytes   (op_bytes),
    .done_bytes (done_bytes),
    .take       (take),
    .bus_data   (bus_data),
    .operand    (rsp_data)
  );

  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_pulse_idle_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_ready && !bus_strobe));
endmodule

// File: tb/tb_dbs_read_seq.sv
module tb_dbs_read_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic [31:0] bus_addr;
  logic [1:0]  bus_siz;
  logic        bus_strobe;
  logic [31:0] bus_data;
  logic [1:0]  bus_ack_n;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int cfg_port  = 4;
  int cfg_waits = 0;
  int ncyc = 0;
  int gap_viol = 0;
  int stab_viol = 0;
  logic [31:0] log_addr [8];
  logic [1:0]  log_siz  [8];

  always #5 clk = ~clk;

  dbs_read_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_strobe(bus_strobe), .bus_data(bus_data),
    .bus_ack_n(bus_ack_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [7:0] mem(input logic [31:0] a);
    return ((a[7:0] * 8'd29) ^ 8'h96) | 8'h01;
  endfunction

  function automatic logic [31:0] expect_val(input logic [31:0] a, input logic [1:0] sz);
    int s = (sz == 2'b00) ? 4 : int'(sz);
    logic [31:0] v = '0;
    for (int k = 0; k < s; k++) v = (v << 8) | {24'h0, mem(a + 32'(k))};
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // slave model: drives acknowledge and lanes at negative edges
  initial begin
    int wcnt = 0;
    bit acked = 0;
    logic [31:0] st_a = '0;
    logic [1:0]  st_s = '0;
    logic [31:0] b;
    bus_ack_n = 2'b11;
    bus_data  = 32'hDEAD_BEEF;
    forever begin
      @(negedge clk);
      if (acked) begin
        bus_ack_n = 2'b11;
        bus_data  = 32'hDEAD_BEEF;
        acked = 0;
        wcnt = 0;
        if (bus_strobe) gap_viol++;
      end else if (bus_strobe) begin
        if (wcnt == 0) begin st_a = bus_addr; st_s = bus_siz; end
        else if (bus_addr != st_a || bus_siz != st_s) stab_viol++;
        if (wcnt >= cfg_waits) begin
          if (cfg_port == 4) begin
            b = {bus_addr[31:2], 2'b00};
            bus_data = {mem(b), mem(b + 1), mem(b + 2), mem(b + 3)};
            bus_ack_n = 2'b00;
          end else if (cfg_port == 2) begin
            b = {bus_addr[31:1], 1'b0};
            bus_data = {mem(b), mem(b + 1), 16'hEEEE};
            bus_ack_n = 2'b01;
          end else begin
            bus_data = {mem(bus_addr), 24'hEEEEEE};
            bus_ack_n = 2'b10;
          end
          if (ncyc < 8) begin log_addr[ncyc] = bus_addr; log_siz[ncyc] = bus_siz; end
          ncyc++;
          acked = 1;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
    finish_run();
  end

  task automatic start_read(input logic [31:0] a, input logic [1:0] sz,
                            input int port, input int waits);
    cfg_port = port; cfg_waits = waits;
    ncyc = 0; gap_viol = 0; stab_viol = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready when idle", 32'(req_ready), 32'h1);
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [31:0] got);
    int n = 0;
    while (!rsp_valid && n < 400) begin @(negedge clk); n++; end
    got = rsp_data;
  endtask

  task automatic judge(input logic [31:0] a, input logic [1:0] sz, input int port,
                       input logic [31:0] got, input string req);
    int s = (sz == 2'b00) ? 4 : int'(sz);
    int rem = s;
    int i = 0;
    logic [31:0] ea = a;
    int n;
    check(got == expect_val(a, sz), req, "operand", got, expect_val(a, sz));
    while (rem > 0) begin
      n = (port < rem) ? port : rem;
      if (i < 8) begin
        check(log_addr[i] == ea, req, "cycle address", log_addr[i], ea);
        check(log_siz[i] == 2'(rem), req, "cycle size", 32'(log_siz[i]), 32'(2'(rem)));
      end
      ea = ea + 32'(n); rem -= n; i++;
    end
    check(ncyc == i, req, "cycle count", 32'(ncyc), 32'(i));
    check(gap_viol == 0, "R10", "strobe gap", 32'(gap_viol), 32'h0);
    check(stab_viol == 0, "R4", "wait stability", 32'(stab_viol), 32'h0);
  endtask

  task automatic run_read(input logic [31:0] a, input logic [1:0] sz, input int port,
                          input int waits, input string req);
    logic [31:0] got;
    start_read(a, sz, port, waits);
    wait_rsp(got);
    check(rsp_valid == 1'b1, "R11", "done pulse", 32'(rsp_valid), 32'h1);
    judge(a, sz, port, got, req);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "pulse width", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(bus_strobe == 1'b0, "R1", "strobe", 32'(bus_strobe), 32'h0);
    check(req_ready == 1'b1, "R1", "ready", 32'(req_ready), 32'h1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'h0);
    check(rsp_data == 32'h0, "R1", "rsp_data", rsp_data, 32'h0);
  endtask

  task automatic t_full_port();
    run_read(32'h0000_1000, 2'b00, 4, 0, "R5");
    for (int o = 0; o < 4; o++) run_read(32'h0000_2040 + 32'(o), 2'b01, 4, 0, "R9");
    run_read(32'h0000_2042, 2'b10, 4, 1, "R9");
    run_read(32'h0000_2044, 2'b10, 4, 0, "R5");
  endtask

  task automatic t_half_port();
    run_read(32'h0000_3000, 2'b00, 2, 0, "R7");
    run_read(32'h0000_3006, 2'b10, 2, 0, "R6");
    run_read(32'h0000_3009, 2'b01, 2, 0, "R6");
    run_read(32'h0000_300A, 2'b01, 2, 2, "R6");
  endtask

  task automatic t_byte_port();
    run_read(32'h0000_4100, 2'b00, 1, 0, "R8");
    run_read(32'h0000_4202, 2'b10, 1, 0, "R6");
    run_read(32'h0000_4303, 2'b01, 1, 0, "R3");
  endtask

  task automatic t_waits();
    run_read(32'h0000_5000, 2'b00, 1, 3, "R4");
    run_read(32'h0000_5104, 2'b00, 2, 5, "R4");
  endtask

  task automatic t_ignored();
    logic [31:0] got;
    int highs = 0;
    start_read(32'h0000_6000, 2'b00, 1, 2);
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R2", "ready while busy", 32'(req_ready), 32'h0);
    req_valid = 1'b1; req_addr = 32'h0000_6500; req_size = 2'b01;
    @(negedge clk);
    req_valid = 1'b0;
    wait_rsp(got);
    judge(32'h0000_6000, 2'b00, 1, got, "R2");
    repeat (6) begin @(negedge clk); if (bus_strobe) highs++; end
    check(highs == 0, "R2", "no cycle from busy offer", 32'(highs), 32'h0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] got;
    start_read(32'h0000_7000, 2'b00, 2, 1);
    wait_rsp(got);
    check(got == expect_val(32'h0000_7000, 2'b00), "R11", "first operand",
          got, expect_val(32'h0000_7000, 2'b00));
    check(req_ready == 1'b1, "R2", "ready with pulse", 32'(req_ready), 32'h1);
    ncyc = 0; gap_viol = 0; stab_viol = 0;
    req_valid = 1'b1; req_addr = 32'h0000_7102; req_size = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    check(bus_strobe && bus_addr == 32'h0000_7102 && bus_siz == 2'b10, "R3",
          "overlapped start", bus_addr, 32'h0000_7102);
    wait_rsp(got);
    judge(32'h0000_7102, 2'b10, 2, got, "R11");
  endtask

  task automatic t_reset_mid();
    start_read(32'h0000_8000, 2'b00, 1, 1);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(bus_strobe == 1'b0, "R12", "strobe after reset", 32'(bus_strobe), 32'h0);
    check(req_ready == 1'b1, "R12", "idle after reset", 32'(req_ready), 32'h1);
    check(rsp_data == 32'h0, "R12", "operand cleared", rsp_data, 32'h0);
    repeat (2) @(negedge clk);
    run_read(32'h0000_8100, 2'b00, 4, 0, "R12");
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_size = 2'b00; req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full_port();
    t_half_port();
    t_byte_port();
    t_waits();
    t_ignored();
    t_back_to_back();
    t_reset_mid();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule